// File: doc/BRIEF.md
# Noise Voice Shift-Register Generator

This block is the noise voice of a four-voice square-wave sound generator. A prescaled clock enable (`tick`) drives a period counter. Each time the counter runs out, a linear feedback shift register moves one place. The least significant bit of that register is the 1-bit noise output, which is later scaled and mixed outside this block. A 3-bit control word picks one of two modes. In white mode, feedback comes from two taps. In periodic mode, the second tap is suppressed, so the single seed bit circulates as a ring. The same word picks the shift rate: one of three fixed rates, or a rate that follows the half period of tone channel 2.

Parameters set the register width, the two tap positions, XOR or XNOR feedback for the second tap, and the reseed rule. Under the reseed rule, a write can reseed the register every time, or only when it flips the mode bit. The bus decode stays outside this block. It delivers a write strobe and the three control bits. The tone-2 half period arrives already resolved, with a written zero mapped to whatever the system chooses.

Top module: `noise_lfsr_voice`

## Requirements
- R1: A synchronous active-high `rst` loads the register with its seed, clears the period counter and clears the control word to 0. `noise_out` reads 0 after reset.
- R2: On each shift, the register moves right by one place and the feedback bit enters at the top bit (LFSR_W-1). `noise_out` is bit 0 of the register.
- R3: White mode is control bit 2 = 1. In white mode the feedback is bit TAP_A XOR (bit TAP_B XOR XNOR_FB).
- R4: Periodic mode is control bit 2 = 0. In periodic mode the feedback is bit TAP_A alone. With TAP_A = 0, the single seed bit recirculates, so a 1 appears on `noise_out` once every LFSR_W shifts.
- R5: Control bits 1:0 select the shift period when they are 0, 1 or 2. These values give 32, 64 and 128 ticks between shifts (2^(BASE_LOG2+rate)).
- R6: Control bits 1:0 = 3 give a period of twice `tone2_half`, read live at every reload. A change on `tone2_half` therefore takes effect without a control write. A resulting period of 0 shifts on every tick.
- R7: With `tick` low, the counter and the register hold, so `noise_out` holds.
- R8: With RESEED_ON_CHANGE = 0, every control write reloads the seed. The seed is the top bit alone set. A write takes priority over a shift in the same cycle.
- R9: With RESEED_ON_CHANGE = 1, only a write whose bit 2 differs from the stored bit 2 reloads the seed. Any other write only updates the control word.
- R10: A control write does not touch the period counter. After reset, the first tick shifts at once, because the cleared counter counts as expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Divided-clock enable, one cycle wide |
| ctrl_wr | input | 1 | Strobe: write `ctrl_data` to the control word |
| ctrl_data | input | 3 | Bit 2 white/periodic, bits 1:0 rate select |
| tone2_half | input | TONE_W | Resolved half period of tone channel 2 |
| noise_out | output | 1 | Noise bit (register bit 0) |

## Verification
The hardest case to reach from the ports is the write on the change-only variant that leaves the mode bit alone. Such a write must not reseed, yet its only visible effect is a phase in the shift sequence. To make that phase observable, the bench uses the tone-following rate with a zero half period, so the ring steps on every tick. It then waits until the 1 sits in bit 0 on that variant and issues the write. A missing reseed puts the next 1 on tick LFSR_W. A wrong reseed puts it one tick earlier.

// File: rtl/noise_voice_pkg.sv
package noise_voice_pkg;

  // bit 2: white (1) / periodic (0); bits 1:0: rate select
  typedef struct packed {
    logic       white;
    logic [1:0] rate;
  } noise_ctrl_t;

  localparam logic [1:0] RATE_FOLLOW = 2'd3;

  // Ticks between shifts for a rate selection.
  function automatic int unsigned shift_period(input logic [1:0] rate,
                                               input int unsigned tone_half,
                                               input int unsigned base_log2);
    if (rate == RATE_FOLLOW) return tone_half << 1;
    return 32'd1 << (base_log2 + 32'(rate));
  endfunction

  // Second tap only participates in white mode.
  function automatic logic feedback_bit(input logic tap_a, input logic tap_b,
                                        input logic white, input logic xnor_fb);
    return tap_a ^ (white & (tap_b ^ xnor_fb));
  endfunction

endpackage

// File: rtl/noise_ctrl_reg.sv
module noise_ctrl_reg
  import noise_voice_pkg::*;
#(
  parameter bit RESEED_ON_CHANGE = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  noise_ctrl_t wdata,
  output noise_ctrl_t ctrl_q,
  output logic        reseed
);

  logic mode_flip;
  assign mode_flip = wdata.white != ctrl_q.white;

  generate
    if (RESEED_ON_CHANGE) begin : g_on_change
      assign reseed = wr && mode_flip;
    end else begin : g_on_any
      assign reseed = wr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)     ctrl_q <= '0;
    else if (wr) ctrl_q <= wdata;
  end

  // R5: a write lands in the control word on the next cycle
  assert_ctrl_capture_R5: assert property (@(posedge clk) disable iff (rst)
    wr |=> ctrl_q == $past(wdata));

  // R9: without a write the control word holds
  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(ctrl_q));

endmodule

// File: rtl/noise_period_ctr.sv
module noise_period_ctr
  import noise_voice_pkg::*;
#(
  parameter int unsigned TONE_W    = 11,
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned BASE_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        rate,
  input  logic [TONE_W-1:0] tone_half,
  output logic              step
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period;

  assign period = CNT_W'(shift_period(rate, 32'(tone_half), BASE_LOG2));
  // expired when one decrement would reach zero or below
  assign step   = tick && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= step ? period : cnt_q - CNT_W'(1);
  end

  // R7: idle cycles leave the count alone
  assert_cnt_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));

  // R6: expiry reloads the live period
  assert_cnt_reload_R6: assert property (@(posedge clk) disable iff (rst)
    step |=> cnt_q == $past(period));

  // R5: non-expiring ticks count down by one
  assert_cnt_down_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && !step) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

endmodule

// File: rtl/noise_shift_reg.sv
module noise_shift_reg
  import noise_voice_pkg::*;
#(
  parameter int unsigned W       = 15,
  parameter int unsigned TAP_A   = 0,
  parameter int unsigned TAP_B   = 1,
  parameter bit          XNOR_FB = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         reseed,
  input  logic         white,
  output logic [W-1:0] lfsr_q
);

  localparam logic [W-1:0] SEED = W'(1) << (W - 1);

  logic fb;
  assign fb = feedback_bit(lfsr_q[TAP_A], lfsr_q[TAP_B], white, XNOR_FB);

  always_ff @(posedge clk) begin
    if (rst || reseed) lfsr_q <= SEED;
    else if (step)     lfsr_q <= {fb, lfsr_q[W-1:1]};
  end

  // R8: reseed loads the single top bit
  assert_reseed_value_R8: assert property (@(posedge clk) disable iff (rst)
    reseed |=> lfsr_q == SEED);

  // R2: a shift moves every bit one place right
  assert_shift_right_R2: assert property (@(posedge clk) disable iff (rst)
    (step && !reseed) |=> lfsr_q[W-2:0] == $past(lfsr_q[W-1:1]));

  // R4: periodic mode recirculates tap A alone
  assert_ring_feed_R4: assert property (@(posedge clk) disable iff (rst)
    (step && !reseed && !white) |=> lfsr_q[W-1] == $past(lfsr_q[TAP_A]));

  // R3: white mode combines both taps
  assert_white_feed_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !reseed && white) |=>
      lfsr_q[W-1] == ($past(lfsr_q[TAP_A]) ^ $past(lfsr_q[TAP_B]) ^ XNOR_FB));

  // R7: no shift and no reseed leaves the register alone
  assert_reg_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!step && !reseed) |=> $stable(lfsr_q));

endmodule

// File: rtl/noise_lfsr_voice.sv
module noise_lfsr_voice
  import noise_voice_pkg::*;
#(
  parameter int unsigned LFSR_W           = 15,
  parameter int unsigned TAP_A            = 0,
  parameter int unsigned TAP_B            = 1,
  parameter bit          XNOR_FB          = 1'b0,
  parameter bit          RESEED_ON_CHANGE = 1'b0,
  parameter int unsigned TONE_W           = 11,
  parameter int unsigned BASE_LOG2        = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ctrl_wr,
  input  logic [2:0]        ctrl_data,
  input  logic [TONE_W-1:0] tone2_half,
  output logic              noise_out
);

  localparam int unsigned CNT_W =
    (TONE_W + 1 > BASE_LOG2 + 3) ? TONE_W + 1 : BASE_LOG2 + 3;

  noise_ctrl_t       ctrl_q;
  logic              reseed;
  logic              step;
  logic [LFSR_W-1:0] lfsr_q;

  noise_ctrl_reg #(.RESEED_ON_CHANGE(RESEED_ON_CHANGE)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr     (ctrl_wr),
    .wdata  (noise_ctrl_t'(ctrl_data)),
    .ctrl_q (ctrl_q),
    .reseed (reseed)
  );

  noise_period_ctr #(.TONE_W(TONE_W), .CNT_W(CNT_W), .BASE_LOG2(BASE_LOG2)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .rate      (ctrl_q.rate),
    .tone_half (tone2_half),
    .step      (step)
  );

  noise_shift_reg #(.W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .XNOR_FB(XNOR_FB)) u_sr (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .reseed (reseed),
    .white  (ctrl_q.white),
    .lfsr_q (lfsr_q)
  );

  assign noise_out = lfsr_q[0];

  // R8: the seed never shows a 1 on the output
  assert_seed_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    reseed |=> !noise_out);

  // R10: a write alone never shifts the register
  assert_write_no_shift_R10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !tick && !reseed) |=> $stable(noise_out));

endmodule

// File: tb/sim_noise_lfsr_voice.sv
module sim_noise_lfsr_voice;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst  = 1'b1;
  logic        tick = 1'b0;
  logic        wr   = 1'b0;
  logic [2:0]  cd   = 3'd0;
  logic [10:0] tone = 11'd0;
  logic        out0, out1;

  noise_lfsr_voice u0 (
    .clk(clk), .rst(rst), .tick(tick), .ctrl_wr(wr), .ctrl_data(cd),
    .tone2_half(tone), .noise_out(out0));

  noise_lfsr_voice #(.LFSR_W(16), .TAP_A(0), .TAP_B(3), .XNOR_FB(1'b1),
                     .RESEED_ON_CHANGE(1'b1)) u1 (
    .clk(clk), .rst(rst), .tick(tick), .ctrl_wr(wr), .ctrl_data(cd),
    .tone2_half(tone), .noise_out(out1));

  int    total = 0;
  int    fails = 0;
  bit    done  = 1'b0;
  string cur_req = "R1";

  // behavioural model, one slot per instance
  int       mw  [2] = '{15, 16};
  int       ta  [2] = '{0, 0};
  int       tb  [2] = '{1, 3};
  int       xn  [2] = '{0, 1};
  int       chg [2] = '{0, 1};
  longint   ml  [2];
  int       mc  [2];
  logic [2:0] mctrl [2];

  // {ctrl[2:0], tone[10:0], ticks[11:0]}
  localparam logic [25:0] VEC [8] = '{
    {3'd4, 11'd5,  12'd200},
    {3'd5, 11'd5,  12'd300},
    {3'd6, 11'd5,  12'd600},
    {3'd7, 11'd3,  12'd300},
    {3'd3, 11'd7,  12'd200},
    {3'd7, 11'd0,  12'd400},
    {3'd1, 11'd2,  12'd300},
    {3'd7, 11'd9,  12'd150}
  };

  function automatic int mperiod(input logic [2:0] c, input int t);
    case (c[1:0])
      2'd0: return 32;
      2'd1: return 64;
      2'd2: return 128;
      default: return t + t;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      ml[i] = longint'(1) << (mw[i] - 1);
      mc[i] = 0;
      mctrl[i] = 3'd0;
    end
  endtask

  task automatic model_write(input logic [2:0] c);
    for (int i = 0; i < 2; i++) begin
      if (chg[i] == 0 || c[2] != mctrl[i][2]) ml[i] = longint'(1) << (mw[i] - 1);
      mctrl[i] = c;
    end
  endtask

  task automatic model_tick();
    int b;
    for (int i = 0; i < 2; i++) begin
      mc[i] = mc[i] - 1;
      if (mc[i] <= 0) begin
        b = int'((ml[i] >> ta[i]) & 1);
        if (mctrl[i][2]) b = b ^ int'((ml[i] >> tb[i]) & 1) ^ xn[i];
        ml[i] = (ml[i] >> 1) | (longint'(b) << (mw[i] - 1));
        mc[i] = mperiod(mctrl[i], int'(tone));
      end
    end
  endtask

  task automatic cycle(input bit t, input bit w, input logic [2:0] c);
    @(negedge clk);
    tick = t; wr = w; cd = c;
    @(posedge clk);
    if (w) model_write(c);
    if (t) model_tick();
    #2;
    check(out0 == ml[0][0], cur_req, int'(out0), int'(ml[0][0]));
    check(out1 == ml[1][0], cur_req, int'(out1), int'(ml[1][0]));
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) cycle(1'b1, 1'b0, cd);
  endtask

  task automatic count_rises(input int n, output int r0, output int r1);
    logic p0, p1;
    p0 = out0; p1 = out1; r0 = 0; r1 = 0;
    for (int k = 0; k < n; k++) begin
      cycle(1'b1, 1'b0, cd);
      if (out0 && !p0) r0++;
      if (out1 && !p1) r1++;
      p0 = out0; p1 = out1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b0; wr = 1'b0; cd = 3'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    #1;
    check(out0 == 1'b0, "R1", int'(out0), 0);
    check(out1 == 1'b0, "R1", int'(out1), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int r0, r1, ones0, ones1, first0, first1;
    logic h0, h1;

    do_reset();

    // R10/R5/R2: periodic rate 32 from a cleared counter: shifts at ticks 1, 33, ...
    cur_req = "R5";
    cycle(1'b0, 1'b1, 3'd0);
    for (int k = 1; k <= 449; k++) begin
      cycle(1'b1, 1'b0, 3'd0);
      if (k == 416) check(out0 == 1'b0, "R2", int'(out0), 0);
      if (k == 417) check(out0 == 1'b1, "R5", int'(out0), 1);
      if (k == 448) check(out1 == 1'b0, "R10", int'(out1), 0);
      if (k == 449) check(out1 == 1'b1, "R10", int'(out1), 1);
    end

    // R4: ring with tone-follow period 0 shifts every tick
    cur_req = "R4";
    tone = 11'd0;
    cycle(1'b0, 1'b1, 3'b111);
    cycle(1'b0, 1'b1, 3'b011);
    ticks(40);
    ones0 = 0; ones1 = 0;
    for (int k = 0; k < 160; k++) begin
      cycle(1'b1, 1'b0, cd);
      if (k < 150) ones0 += int'(out0);
      ones1 += int'(out1);
    end
    check(ones0 == 10, "R4", ones0, 10);
    check(ones1 == 10, "R4", ones1, 10);

    // R8/R9: same-mode write; u0 reseeds, u1 keeps its phase
    cur_req = "R9";
    for (int k = 0; k < 20 && !out1; k++) cycle(1'b1, 1'b0, cd);
    check(out1 == 1'b1, "R9", int'(out1), 1);
    cycle(1'b0, 1'b1, 3'b011);
    first0 = 0; first1 = 0;
    for (int k = 1; k <= 16; k++) begin
      cycle(1'b1, 1'b0, cd);
      if (out0 && first0 == 0) first0 = k;
      if (out1 && first1 == 0) first1 = k;
    end
    check(first0 == 14, "R8", first0, 14);
    check(first1 == 16, "R9", first1, 16);

    // R6: period follows tone2_half live
    cur_req = "R6";
    tone = 11'd4;
    ticks(200);
    count_rises(240, r0, r1);
    check(r0 == 2, "R6", r0, 2);
    tone = 11'd8;
    ticks(300);
    count_rises(240, r0, r1);
    check(r0 == 1, "R6", r0, 1);

    // R7: no tick, nothing moves even with tone changing
    cur_req = "R7";
    h0 = out0; h1 = out1;
    for (int k = 0; k < 60; k++) begin
      tone = 11'(k);
      cycle(1'b0, 1'b0, cd);
    end
    check(out0 == h0, "R7", int'(out0), int'(h0));
    check(out1 == h1, "R7", int'(out1), int'(h1));
    tone = 11'd8;

    // R3/R4: vector table, ticks with gaps
    for (int e = 0; e < 8; e++) begin
      tone = VEC[e][22:12];
      cur_req = VEC[e][25] ? "R3" : "R4";
      cycle(1'b0, 1'b1, VEC[e][25:23]);
      for (int k = 0; k < int'(VEC[e][11:0]); k++)
        cycle((k % 4) != 3, 1'b0, VEC[e][25:23]);
    end

    // R1/R10: reset in mid-run, then resume
    do_reset();
    cur_req = "R10";
    ticks(100);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule